// File: doc/BRIEF.md
# Framebuffer Scan-Out Address Generator

This block sits between a raster timing source and frame memory for a fixed 640 by 480 true-colour display. For every visible pixel coordinate that the timing source presents, it issues one word read to frame memory. The address of that read is formed from the upper part of a programmable base register and the pixel position. Each row occupies a stride of 1024 words in memory. The 32-bit words that come back are split into 8-bit red, green and blue outputs together with a data-enable flag. When no word is returned, all three colour outputs are driven to zero.

Software sees two 32-bit registers at byte offsets 0 and 4. Offset 0 holds the frame base, and it reads back exactly as written, so software can use it to probe bus byte order. Offset 4 is a control word. Its bit 0 enables scan-out and its bit 1 turns the picture upside down by walking the raster in reverse. Neither register is used directly by the scan logic. Each one is copied into a working set on a frame-start pulse, so a frame never mixes two settings.

Top module: `fbs_scanout`

## Requirements
- R1: After reset both registers read as zero, no memory read is requested, and the colour outputs and data-enable are low.
- R2: Byte offset 0 (address bit 2 clear) reads back the full 32-bit value last written there. Byte offset 4 (address bit 2 set) holds two bits: bit 0 is enable and bit 1 is rotate. It reads them zero-extended.
- R3: In normal order, pixel (x, y) requests word address {base[31:21], y[8:0], x[9:0]}, that is base_hi*2^19 + y*1024 + x. Base bits 20:0 have no effect.
- R4: With rotate set, pixel (x, y) requests the address that pixel (639-x, 479-y) would use in normal order.
- R5: While the working enable bit is clear, no memory read is requested.
- R6: No read is requested when the active input is low, when x is 640 or more, or when y is 480 or more.
- R7: Writes to either register change the addresses produced only after the next frame-start pulse.
- R8: One cycle after a returned word is flagged valid, red shows bits 23:16, green shows bits 15:8, blue shows bits 7:0 and data-enable is high. Bits 31:24 have no effect.
- R9: One cycle after a cycle with no valid returned word, data-enable is low and all colour outputs are zero.
- R10: A read request and its address appear on the clock edge that samples the qualifying pixel coordinate, one cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset; bit 2 selects the register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| frame_start | input | 1 | One-cycle pulse at the start of a frame; loads the working settings |
| px_active | input | 1 | Timing source marks a pixel slot |
| px_x | input | 10 | Pixel column |
| px_y | input | 9 | Pixel row |
| mem_req | output | 1 | Frame memory read request |
| mem_addr | output | 30 | Word address of the read |
| mem_rvalid | input | 1 | Returned word is valid |
| mem_rdata | input | 32 | Returned pixel word |
| pix_de | output | 1 | Colour outputs carry a pixel |
| pix_red | output | 8 | Red level |
| pix_green | output | 8 | Green level |
| pix_blue | output | 8 | Blue level |

## Verification
The hardest case to reach from the ports is a register write that lands mid-frame. The write must not leak into the current addresses until a frame-start pulse arrives. The stimulus first sets a known base and normal order and pulses frame start. It then writes rotate and a new base with no pulse, probes a pixel, and expects the old mapping. It pulses frame start again and expects the rotated address built from the new base. Corner coordinates at both ends of the raster are probed in both scan orders, and coordinates one past the visible edge are probed as well.

// File: rtl/fbs_pkg.sv
// Shared definitions for the scan-out block: register selection and
// control bit positions. Assumes a two-register map.
package fbs_pkg;
    typedef enum logic {
        SEL_BASE = 1'b0,
        SEL_CTRL = 1'b1
    } fbs_sel_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_ROT_BIT = 1;
    localparam int CTRL_W       = 2;
endpackage

// File: rtl/fbs_regs.sv
// Register slave with per-frame working copy.
// Holds the base word and the control bits written by software. Copies
// them into a working set on frame_start. Assumes frame_start is a
// single-cycle pulse given while no pixel is active.
module fbs_regs
    import fbs_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int BASE_KEEP = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  fbs_sel_e             sel,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 frame_start,
    output logic                 act_en,
    output logic                 act_rot,
    output logic [BASE_KEEP-1:0] act_base_hi
);
    logic [DATA_W-1:0] base_q;
    logic [CTRL_W-1:0] ctrl_q;

    // Software-visible registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_BASE) base_q <= wr_data;
            else                 ctrl_q <= wr_data[CTRL_W-1:0];
        end
    end

    // Read mux: the base comes back whole, control zero-extended.
    always_comb begin
        if (sel == SEL_BASE) rd_data = base_q;
        else                 rd_data = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
    end

    // Working copy, refreshed only at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_en      <= 1'b0;
            act_rot     <= 1'b0;
            act_base_hi <= '0;
        end else if (frame_start) begin
            act_en      <= ctrl_q[CTRL_EN_BIT];
            act_rot     <= ctrl_q[CTRL_ROT_BIT];
            act_base_hi <= base_q[DATA_W-1 -: BASE_KEEP];
        end
    end
endmodule

// File: rtl/fbs_addr_gen.sv
// Request and address generator.
// Qualifies each presented coordinate against the visible window and the
// working enable. Mirrors the coordinate when rotating. Registers a word
// address {base_hi, row, column}. Assumes the row stride is 2**X_W words.
module fbs_addr_gen #(
    parameter int X_ACT     = 640,
    parameter int Y_ACT     = 480,
    parameter int X_W       = 10,
    parameter int Y_W       = 9,
    parameter int BASE_KEEP = 11,
    parameter bit ROT_EN    = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           px_active,
    input  logic [X_W-1:0]                 px_x,
    input  logic [Y_W-1:0]                 px_y,
    input  logic                           en,
    input  logic                           rot,
    input  logic [BASE_KEEP-1:0]           base_hi,
    output logic                           req,
    output logic [BASE_KEEP+Y_W+X_W-1:0]   addr
);
    localparam logic [X_W-1:0] X_LAST = X_W'(X_ACT - 1);
    localparam logic [Y_W-1:0] Y_LAST = Y_W'(Y_ACT - 1);
    localparam logic [X_W-1:0] X_LIM  = X_W'(X_ACT);
    localparam logic [Y_W-1:0] Y_LIM  = Y_W'(Y_ACT);

    logic           in_win;
    logic [X_W-1:0] sx;
    logic [Y_W-1:0] sy;

    // Window and enable qualification.
    assign in_win = px_active && en && (px_x < X_LIM) && (px_y < Y_LIM);

    // Scan-order selection: mirror both axes when rotation is built in and on.
    generate
        if (ROT_EN) begin : g_rot
            always_comb begin
                if (rot) begin
                    sx = X_LAST - px_x;
                    sy = Y_LAST - px_y;
                end else begin
                    sx = px_x;
                    sy = px_y;
                end
            end
        end else begin : g_norot
            always_comb begin
                sx = px_x;
                sy = px_y;
            end
        end
    endgenerate

    // Registered request and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req  <= 1'b0;
            addr <= '0;
        end else begin
            req <= in_win;
            if (in_win) addr <= {base_hi, sy, sx};
        end
    end
endmodule

// File: rtl/fbs_unpack.sv
// Pixel unpacker.
// Splits a returned word into three colour channels and blanks them when
// no word is returned. Assumes the channels are packed below the top byte,
// red highest.
module fbs_unpack #(
    parameter int DATA_W = 32,
    parameter int CH_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rvalid,
    input  logic [DATA_W-1:0] rdata,
    output logic              de,
    output logic [CH_W-1:0]   red,
    output logic [CH_W-1:0]   green,
    output logic [CH_W-1:0]   blue
);
    // Register the channels, or zeros when no word arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || !rvalid) begin
            de    <= 1'b0;
            red   <= '0;
            green <= '0;
            blue  <= '0;
        end else begin
            de    <= 1'b1;
            red   <= rdata[3*CH_W-1 -: CH_W];
            green <= rdata[2*CH_W-1 -: CH_W];
            blue  <= rdata[CH_W-1 -: CH_W];
        end
    end
endmodule

// File: rtl/fbs_scanout.sv
// Scan-out top level.
// Ties the register slave, the address generator and the unpacker
// together. Assumes an external timing source and a memory that flags
// returned words with mem_rvalid.
module fbs_scanout
    import fbs_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_AW    = 3,
    parameter int X_ACT     = 640,
    parameter int Y_ACT     = 480,
    parameter int X_W       = 10,
    parameter int Y_W       = 9,
    parameter int BASE_KEEP = 11,
    parameter int CH_W      = 8,
    parameter int MEM_AW    = BASE_KEEP + Y_W + X_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              frame_start,
    input  logic              px_active,
    input  logic [X_W-1:0]    px_x,
    input  logic [Y_W-1:0]    px_y,
    output logic              mem_req,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              pix_de,
    output logic [CH_W-1:0]   pix_red,
    output logic [CH_W-1:0]   pix_green,
    output logic [CH_W-1:0]   pix_blue
);
    localparam int SEL_BIT = 2;

    fbs_sel_e             sel;
    logic                 act_en;
    logic                 act_rot;
    logic [BASE_KEEP-1:0] act_base_hi;

    // Word-sized registers: byte offset bit 2 picks one.
    assign sel = fbs_sel_e'(reg_addr[SEL_BIT]);

    fbs_regs #(.DATA_W(DATA_W), .BASE_KEEP(BASE_KEEP)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .sel(sel),
        .wr_data(reg_wdata), .rd_data(reg_rdata), .frame_start(frame_start),
        .act_en(act_en), .act_rot(act_rot), .act_base_hi(act_base_hi)
    );

    fbs_addr_gen #(
        .X_ACT(X_ACT), .Y_ACT(Y_ACT), .X_W(X_W), .Y_W(Y_W),
        .BASE_KEEP(BASE_KEEP), .ROT_EN(1'b1)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .px_active(px_active), .px_x(px_x),
        .px_y(px_y), .en(act_en), .rot(act_rot), .base_hi(act_base_hi),
        .req(mem_req), .addr(mem_addr)
    );

    fbs_unpack #(.DATA_W(DATA_W), .CH_W(CH_W)) u_unpack (
        .clk(clk), .rst_n(rst_n), .rvalid(mem_rvalid), .rdata(mem_rdata),
        .de(pix_de), .red(pix_red), .green(pix_green), .blue(pix_blue)
    );
endmodule

// File: rtl/fbs_scanout_chk.sv
// Property checker for the scan-out block, attached by bind.
module fbs_scanout_chk #(
    parameter int X_ACT = 640,
    parameter int Y_ACT = 480,
    parameter int X_W   = 10,
    parameter int Y_W   = 9,
    parameter int CH_W  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           frame_start,
    input logic           px_active,
    input logic [X_W-1:0] px_x,
    input logic [Y_W-1:0] px_y,
    input logic           mem_req,
    input logic           mem_rvalid,
    input logic           pix_de,
    input logic [CH_W-1:0] pix_red,
    input logic [CH_W-1:0] pix_green,
    input logic [CH_W-1:0] pix_blue,
    input logic           act_en,
    input logic           act_rot
);
    assert_req_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(act_en));

    assert_req_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($past(px_active) && ($past(px_x) < X_W'(X_ACT))
                     && ($past(px_y) < Y_W'(Y_ACT))));

    assert_req_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (px_active && act_en && (px_x < X_W'(X_ACT)) && (px_y < Y_W'(Y_ACT)))
        |=> mem_req);

    assert_cfg_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(act_en) && $stable(act_rot)));

    assert_de_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |=> pix_de);

    assert_blank_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_de |-> (pix_red == '0 && pix_green == '0 && pix_blue == '0));
endmodule

bind fbs_scanout fbs_scanout_chk #(
    .X_ACT(X_ACT), .Y_ACT(Y_ACT), .X_W(X_W), .Y_W(Y_W), .CH_W(CH_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .px_active(px_active), .px_x(px_x), .px_y(px_y),
    .mem_req(mem_req), .mem_rvalid(mem_rvalid), .pix_de(pix_de),
    .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
    .act_en(act_en), .act_rot(act_rot)
);

// File: tb/tb_fbs_scanout.sv
module tb_fbs_scanout;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frame_start = 1'b0;
    logic        px_active = 1'b0;
    logic [9:0]  px_x = '0;
    logic [8:0]  px_y = '0;
    logic        mem_req;
    logic [29:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        pix_de;
    logic [7:0]  pix_red, pix_green, pix_blue;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    fbs_scanout dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
        .px_active(px_active), .px_x(px_x), .px_y(px_y), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .pix_de(pix_de), .pix_red(pix_red), .pix_green(pix_green),
        .pix_blue(pix_blue)
    );

    typedef struct packed {
        logic        rot;
        logic [9:0]  x;
        logic [8:0]  y;
        logic [18:0] off;
    } vec_t;

    // Offsets follow R3/R4: row*1024 + column after mirroring.
    localparam vec_t VEC [0:7] = '{
        '{1'b0, 10'd0,   9'd0,   19'd0},
        '{1'b0, 10'd639, 9'd0,   19'd639},
        '{1'b0, 10'd5,   9'd1,   19'd1029},
        '{1'b0, 10'd639, 9'd479, 19'd491135},
        '{1'b0, 10'd320, 9'd240, 19'd246080},
        '{1'b1, 10'd0,   9'd0,   19'd491135},
        '{1'b1, 10'd639, 9'd479, 19'd0},
        '{1'b1, 10'd100, 9'd200, 19'd286235}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input bit ctrl, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = ctrl ? 3'd4 : 3'd0; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input bit ctrl, output logic [31:0] d);
        @(negedge clk);
        reg_addr = ctrl ? 3'd4 : 3'd0;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    // Present one coordinate for a cycle and capture the request after the edge.
    task automatic probe(input logic act, input logic [9:0] x, input logic [8:0] y,
                         output logic rq, output logic [29:0] ad);
        @(negedge clk);
        px_active = act; px_x = x; px_y = y;
        @(negedge clk);
        rq = mem_req; ad = mem_addr;
        px_active = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        rq;
        logic [29:0] ad;
        logic [31:0] base;
        logic        cur_rot;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_reg(1'b0, rd); check(rd == 0, "R1 base after reset", rd, 0);
        rd_reg(1'b1, rd); check(rd == 0, "R1 ctrl after reset", rd, 0);
        check(!mem_req && !pix_de, "R1 req/de after reset", {mem_req, pix_de}, 0);
        check({pix_red, pix_green, pix_blue} == 0, "R1 rgb after reset",
              {pix_red, pix_green, pix_blue}, 0);
        probe(1'b1, 10'd3, 9'd3, rq, ad);
        check(!rq, "R1 R5 no req while disabled after reset", rq, 0);

        // R2: readback
        base = 32'hABC1_2345;
        wr_reg(1'b0, base);
        rd_reg(1'b0, rd); check(rd == base, "R2 base readback", rd, base);
        wr_reg(1'b1, 32'hFFFF_FFFF);
        rd_reg(1'b1, rd); check(rd == 32'h3, "R2 ctrl readback", rd, 3);

        // R3/R4: vector walk
        wr_reg(1'b1, 32'h1);
        pulse_frame();
        cur_rot = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (VEC[i].rot != cur_rot) begin
                wr_reg(1'b1, {30'd0, VEC[i].rot, 1'b1});
                pulse_frame();
                cur_rot = VEC[i].rot;
            end
            probe(1'b1, VEC[i].x, VEC[i].y, rq, ad);
            check(rq && ad == {base[31:21], VEC[i].off},
                  VEC[i].rot ? "R4 rotated address" : "R3 R10 normal address",
                  {1'b0, rq, ad}, {2'b01, base[31:21], VEC[i].off});
        end

        // R6: outside window / inactive
        probe(1'b1, 10'd640, 9'd0, rq, ad); check(!rq, "R6 x=640", rq, 0);
        probe(1'b1, 10'd0, 9'd480, rq, ad); check(!rq, "R6 y=480", rq, 0);
        probe(1'b0, 10'd10, 9'd10, rq, ad); check(!rq, "R6 inactive", rq, 0);

        // R7: mid-frame writes held until frame start
        wr_reg(1'b1, 32'h1);
        pulse_frame();
        wr_reg(1'b1, 32'h3);
        wr_reg(1'b0, 32'h0060_0000);
        probe(1'b1, 10'd0, 9'd0, rq, ad);
        check(rq && ad == {base[31:21], 19'd0}, "R7 old settings kept",
              {1'b0, rq, ad}, {2'b01, base[31:21], 19'd0});
        pulse_frame();
        probe(1'b1, 10'd0, 9'd0, rq, ad);
        check(rq && ad == {11'd3, 19'd491135}, "R7 R4 new settings at frame",
              {1'b0, rq, ad}, {2'b01, 11'd3, 19'd491135});

        // R5: disable at frame start stops requests
        wr_reg(1'b1, 32'h2);
        pulse_frame();
        probe(1'b1, 10'd1, 9'd1, rq, ad); check(!rq, "R5 disabled", rq, 0);

        // R8/R9: unpacking and blanking
        @(negedge clk); mem_rvalid = 1'b1; mem_rdata = 32'hFF12_3456;
        @(negedge clk); mem_rvalid = 1'b0;
        check(pix_de && {pix_red, pix_green, pix_blue} == 24'h123456, "R8 unpack",
              {7'd0, pix_de, pix_red, pix_green, pix_blue}, 32'h0112_3456);
        @(negedge clk);
        check(!pix_de && {pix_red, pix_green, pix_blue} == 0, "R9 blank",
              {7'd0, pix_de, pix_red, pix_green, pix_blue}, 0);
        @(negedge clk); mem_rvalid = 1'b1; mem_rdata = 32'h00AB_CDEF;
        @(negedge clk); mem_rvalid = 1'b0;
        check(pix_de && {pix_red, pix_green, pix_blue} == 24'hABCDEF, "R8 unpack 2",
              {7'd0, pix_de, pix_red, pix_green, pix_blue}, 32'h01AB_CDEF);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule